// File: doc/BRIEF.md
# Source-Routed Wormhole Input Port

This block is the receive side of one link of a five-port mesh router. A link carries 34-bit flits and two virtual channels (VCs). The upstream sender marks each flit with a per-VC strobe, and the port steers the flit into a one-flit slot owned by that VC. VC0 is the high-priority class and VC1 is the best-effort class. Each VC has its own routing state, its own slot and its own output toward the crossbar, so two packets on different VCs can be in flight through the port at once.

Routing is source-based. The two lowest bits of a header's route field name the output for this hop. The port forwards the header with that field shifted right by two, so the next router finds its own code in the low bits. Switching is wormhole: the path a header claims is held for every following flit of the packet until the tail leaves. A slot is freed only when the output side accepts its flit, and the credit returned upstream for a VC stays low while that VC's slot is occupied.

Each VC lane runs a three-state machine. `LN_IDLE` means no packet is open and the slot is empty. `LN_FWD` means a path is locked and the slot holds a flit. `LN_WAIT` means a path is locked and the slot is empty. There are five transitions:
- IDLE to FWD on a header capture.
- FWD to WAIT on acceptance of a non-tail flit.
- FWD to IDLE on acceptance of a tail or single-flit packet.
- WAIT to FWD on any flit capture.
- IDLE to IDLE when a non-header flit is discarded.

Top module: `wh_input_port`

## Requirements
- R1: After reset, and whenever reset is asserted, both credits (`lnk_resp`) are 1 and every bit of `xb_send` and `xb_lock` is 0.
- R2: A flit presented with `lnk_req[v]` is loaded only into lane v, and the other lane's outputs are not changed by it.
- R3: Flit bits 33 and 32 are the packet-start and packet-end flags. A value of 10 is a header, 11 a single-flit packet, 00 a body flit and 01 a tail. For a header or single-flit packet, route bits 1..0 give the code d, and in the next cycle the lane raises only bit d of its send and lock vectors. Code 0 is the local port and codes 1..3 are the neighbours in clockwise order from the arrival port.
- R4: A forwarded header keeps bits 33..18 unchanged. Its bits 17..0 become the received route field shifted right by two, with zeros filled in at bits 17..16.
- R5: Body and tail flits are forwarded with all 34 bits unchanged.
- R6: A lane's lock bit stays high from the cycle after header capture until the output accepts the tail or single-flit packet. It is 0 in the cycle after that acceptance.
- R7: While a lane's slot holds a flit and `xb_ack` for that lane is low, the lane's credit is 0 and the forwarded flit and its send bit stay unchanged.
- R8: A body or tail flit that arrives on a lane with no open packet is discarded. The lane's credit stays 1 and no send or lock bit rises.
- R9: If both strobes are high in the same cycle, only VC0 takes the flit.
- R10: The two lanes hold open packets at the same time and release them independently.
- R11: `xb_ack` on a lane whose slot is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lnk_req | input | 2 | Per-VC strobe qualifying `lnk_flit` |
| lnk_flit | input | 34 | Incoming flit |
| lnk_resp | output | 2 | Per-VC credit, 1 when that slot can take a flit |
| xb_flit | output | 2x34 | Per-VC flit toward the crossbar, header route field already shifted |
| xb_send | output | 2x4 | Per-VC one-hot send request to the selected output |
| xb_lock | output | 2x4 | Per-VC one-hot path lock held for the whole packet |
| xb_ack | input | 2 | Per-VC acceptance of the presented flit by the output side |

## Verification
A lane stuck in the wrong state shows up at the ports in the next cycle. If it wrongly believes it is idle, the lock drops mid-packet and the credit rises while a flit is still held. If it wrongly believes it is locked, a stray body flit is captured and a send bit rises. A wrong direction register shows at once as a different one-hot send and lock bit. A wrong shift or overwrite of the slot shows as altered forwarded data while the flit waits for acceptance. Every vector compares credits, sends and locks one cycle after its stimulus, so any divergence is caught within one cycle of the edge that caused it.

// File: rtl/wh_pkg.sv
package wh_pkg;

    typedef enum logic [1:0] {
        LN_IDLE = 2'd0,
        LN_FWD  = 2'd1,
        LN_WAIT = 2'd2
    } lane_state_e;

    typedef enum logic [1:0] {
        FK_BODY   = 2'b00,
        FK_TAIL   = 2'b01,
        FK_HEAD   = 2'b10,
        FK_SINGLE = 2'b11
    } flit_kind_e;

    function automatic logic opens_packet(input logic [1:0] ctl);
        return (ctl == FK_HEAD) || (ctl == FK_SINGLE);
    endfunction

    function automatic logic closes_packet(input logic [1:0] ctl);
        return (ctl == FK_TAIL) || (ctl == FK_SINGLE);
    endfunction

endpackage

// File: rtl/wh_dir_decode.sv
module wh_dir_decode #(
    parameter int DIR_W = 2
) (
    input  logic [DIR_W-1:0]        code,
    input  logic                    en,
    output logic [(1<<DIR_W)-1:0]   onehot
);
    localparam int NUM_DST = 1 << DIR_W;

    for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
        assign onehot[d] = en && (code == DIR_W'(d));
    end
endmodule

// File: rtl/wh_vc_lane.sv
module wh_vc_lane
    import wh_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ROUTE_W = 18,
    parameter int DIR_W   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cap,
    input  logic [DATA_W+1:0]          flit_in,
    input  logic                       ack,
    output logic                       resp,
    output logic [DATA_W+1:0]          flit_out,
    output logic [(1<<DIR_W)-1:0]      send,
    output logic [(1<<DIR_W)-1:0]      lock
);
    localparam int FLIT_W  = DATA_W + 2;
    localparam int NUM_DST = 1 << DIR_W;
    localparam int CTL_LO  = FLIT_W - 2;

    lane_state_e             state_q, state_d;
    logic [FLIT_W-1:0]       slot_q;
    logic [DIR_W-1:0]        dir_q;
    logic                    in_opens, slot_closes;
    logic                    load_head, load_body;
    logic                    fwd, locked;
    logic [FLIT_W-1:0]       head_fwd;

    assign in_opens    = opens_packet(flit_in[FLIT_W-1:CTL_LO]);
    assign slot_closes = closes_packet(slot_q[FLIT_W-1:CTL_LO]);
    assign load_head   = (state_q == LN_IDLE) && cap && in_opens;
    assign load_body   = (state_q == LN_WAIT) && cap;
    assign head_fwd    = {flit_in[FLIT_W-1:ROUTE_W], {DIR_W{1'b0}},
                          flit_in[ROUTE_W-1:DIR_W]};

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE: if (cap && in_opens) state_d = LN_FWD;
            LN_FWD:  if (ack)             state_d = slot_closes ? LN_IDLE : LN_WAIT;
            LN_WAIT: if (cap)             state_d = LN_FWD;
            default:                      state_d = LN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            dir_q  <= '0;
        end else if (load_head) begin
            slot_q <= head_fwd;
            dir_q  <= flit_in[DIR_W-1:0];
        end else if (load_body) begin
            slot_q <= flit_in;
        end
    end

    always_comb begin
        fwd    = 1'b0;
        locked = 1'b0;
        unique case (state_q)
            LN_IDLE: begin fwd = 1'b0; locked = 1'b0; end
            LN_FWD:  begin fwd = 1'b1; locked = 1'b1; end
            LN_WAIT: begin fwd = 1'b0; locked = 1'b1; end
            default: begin fwd = 1'b0; locked = 1'b0; end
        endcase
        resp     = !fwd;
        flit_out = slot_q;
    end

    wh_dir_decode #(.DIR_W(DIR_W)) u_send_dec (.code(dir_q), .en(fwd),    .onehot(send));
    wh_dir_decode #(.DIR_W(DIR_W)) u_lock_dec (.code(dir_q), .en(locked), .onehot(lock));

    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_FWD && !ack) |=> (flit_out == $past(flit_out) && !resp && send == $past(send)));

    a_r6_release_on_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_FWD && ack && slot_closes) |=> (lock == '0 && send == '0 && resp));

    a_r3_head_claims_path: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_IDLE && cap && in_opens) |=> ($onehot(send) && lock == send));

    a_r8_stray_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_IDLE && cap && !in_opens) |=> (resp && lock == '0 && send == '0));

    a_r6_send_inside_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (send & ~lock) == '0);

    a_r11_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_WAIT && ack && !cap) |=> (lock == $past(lock) && resp));
endmodule

// File: rtl/wh_input_port.sv
module wh_input_port #(
    parameter int DATA_W  = 32,
    parameter int ROUTE_W = 18,
    parameter int DIR_W   = 2,
    parameter int NUM_VC  = 2
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic [NUM_VC-1:0]                            lnk_req,
    input  logic [DATA_W+1:0]                            lnk_flit,
    output logic [NUM_VC-1:0]                            lnk_resp,
    output logic [NUM_VC-1:0][DATA_W+1:0]                xb_flit,
    output logic [NUM_VC-1:0][(1<<DIR_W)-1:0]            xb_send,
    output logic [NUM_VC-1:0][(1<<DIR_W)-1:0]            xb_lock,
    input  logic [NUM_VC-1:0]                            xb_ack
);
    logic [NUM_VC-1:0] take;

    // lowest-numbered strobe wins: VC0 has priority
    assign take = lnk_req & (~lnk_req + NUM_VC'(1));

    for (genvar v = 0; v < NUM_VC; v++) begin : g_lane
        wh_vc_lane #(
            .DATA_W (DATA_W),
            .ROUTE_W(ROUTE_W),
            .DIR_W  (DIR_W)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap     (take[v]),
            .flit_in (lnk_flit),
            .ack     (xb_ack[v]),
            .resp    (lnk_resp[v]),
            .flit_out(xb_flit[v]),
            .send    (xb_send[v]),
            .lock    (xb_lock[v])
        );
    end

    a_r9_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take) && ((take & ~lnk_req) == '0));
endmodule

// File: tb/wh_input_port_tb.sv
`timescale 1ns/1ps
module wh_input_port_tb;
    logic              clk = 1'b0;
    logic              rst_n;
    logic [1:0]        lnk_req;
    logic [33:0]       lnk_flit;
    logic [1:0]        lnk_resp;
    logic [1:0][33:0]  xb_flit;
    logic [1:0][3:0]   xb_send;
    logic [1:0][3:0]   xb_lock;
    logic [1:0]        xb_ack;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    wh_input_port u_dut (
        .clk(clk), .rst_n(rst_n), .lnk_req(lnk_req), .lnk_flit(lnk_flit),
        .lnk_resp(lnk_resp), .xb_flit(xb_flit), .xb_send(xb_send),
        .xb_lock(xb_lock), .xb_ack(xb_ack)
    );

    // row: tag[59:56] req[55:54] ack[53:52] flit[51:18] resp[17:16]
    //      send0[15:12] lock0[11:8] send1[7:4] lock1[3:0]
    localparam int NV = 17;
    localparam logic [59:0] VEC [NV] = '{
        {4'd3,  2'b01, 2'b00, 2'b10, 32'h0000_000E, 2'b10, 4'b0100, 4'b0100, 4'b0000, 4'b0000},
        {4'd7,  2'b00, 2'b00, 2'b00, 32'h0000_0000, 2'b10, 4'b0100, 4'b0100, 4'b0000, 4'b0000},
        {4'd7,  2'b00, 2'b01, 2'b00, 32'h0000_0000, 2'b11, 4'b0000, 4'b0100, 4'b0000, 4'b0000},
        {4'd2,  2'b10, 2'b00, 2'b10, 32'h0000_0001, 2'b01, 4'b0000, 4'b0100, 4'b0010, 4'b0010},
        {4'd10, 2'b01, 2'b00, 2'b00, 32'hDEAD_BEEF, 2'b00, 4'b0100, 4'b0100, 4'b0010, 4'b0010},
        {4'd10, 2'b00, 2'b11, 2'b00, 32'h0000_0000, 2'b11, 4'b0000, 4'b0100, 4'b0000, 4'b0010},
        {4'd6,  2'b01, 2'b00, 2'b01, 32'h0000_1234, 2'b10, 4'b0100, 4'b0100, 4'b0000, 4'b0010},
        {4'd6,  2'b00, 2'b01, 2'b00, 32'h0000_0000, 2'b11, 4'b0000, 4'b0000, 4'b0000, 4'b0010},
        {4'd2,  2'b10, 2'b00, 2'b01, 32'h0000_5678, 2'b01, 4'b0000, 4'b0000, 4'b0010, 4'b0010},
        {4'd6,  2'b00, 2'b10, 2'b00, 32'h0000_0000, 2'b11, 4'b0000, 4'b0000, 4'b0000, 4'b0000},
        {4'd8,  2'b01, 2'b00, 2'b00, 32'h1111_1111, 2'b11, 4'b0000, 4'b0000, 4'b0000, 4'b0000},
        {4'd11, 2'b00, 2'b01, 2'b00, 32'h0000_0000, 2'b11, 4'b0000, 4'b0000, 4'b0000, 4'b0000},
        {4'd9,  2'b11, 2'b00, 2'b11, 32'h0000_0003, 2'b10, 4'b1000, 4'b1000, 4'b0000, 4'b0000},
        {4'd6,  2'b00, 2'b01, 2'b00, 32'h0000_0000, 2'b11, 4'b0000, 4'b0000, 4'b0000, 4'b0000},
        {4'd3,  2'b10, 2'b00, 2'b11, 32'h0000_0000, 2'b01, 4'b0000, 4'b0000, 4'b0001, 4'b0001},
        {4'd7,  2'b00, 2'b00, 2'b00, 32'h0000_0000, 2'b01, 4'b0000, 4'b0000, 4'b0001, 4'b0001},
        {4'd6,  2'b00, 2'b10, 2'b00, 32'h0000_0000, 2'b11, 4'b0000, 4'b0000, 4'b0000, 4'b0000}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            4'd11: return "R11";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic [1:0] rq, input logic [1:0] ak, input logic [33:0] f);
        lnk_req  = rq;
        xb_ack   = ak;
        lnk_flit = f;
    endtask

    task automatic check_idle(input string tag);
        check(tag, {46'd0, lnk_resp, xb_send, xb_lock}, {46'd0, 2'b11, 16'h0000});
    endtask

    logic [33:0] hdr, body, tail, exp_hdr;

    initial begin
        drive(2'b00, 2'b00, '0);
        rst_n = 1'b0;
        repeat (3) tick();
        check_idle("R1");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][55:54], VEC[i][53:52], VEC[i][51:18]);
            tick();
            check(tag_name(VEC[i][59:56]),
                  {46'd0, lnk_resp, xb_send[0], xb_lock[0], xb_send[1], xb_lock[1]},
                  {46'd0, VEC[i][17:0]});
        end
        drive(2'b00, 2'b00, '0);

        // R4: header route field shifted by one hop
        hdr     = {2'b10, 14'h2ABC, 18'h1E4B7};
        exp_hdr = {hdr[33:18], 2'b00, hdr[17:2]};
        drive(2'b01, 2'b00, hdr);
        tick();
        drive(2'b00, 2'b00, '0);
        check("R4", {30'd0, xb_flit[0]}, {30'd0, exp_hdr});
        check("R3", {60'd0, xb_send[0]}, {60'd0, 4'b1000});
        // R7: held without acceptance, a new strobe on VC0 is refused
        drive(2'b01, 2'b00, {2'b00, 32'h5555_5555});
        repeat (3) tick();
        drive(2'b00, 2'b00, '0);
        check("R7", {29'd0, lnk_resp[0], xb_flit[0]}, {29'd0, 1'b0, exp_hdr});
        drive(2'b00, 2'b01, '0);
        tick();
        // R5: body and tail unmodified
        body = {2'b00, 32'h0123_4567};
        drive(2'b01, 2'b00, body);
        tick();
        check("R5", {30'd0, xb_flit[0]}, {30'd0, body});
        drive(2'b00, 2'b01, '0);
        tick();
        tail = {2'b01, 32'hCAFE_0001};
        drive(2'b01, 2'b00, tail);
        tick();
        check("R5", {30'd0, xb_flit[0]}, {30'd0, tail});
        check("R6", {60'd0, xb_lock[0]}, {60'd0, 4'b1000});
        drive(2'b00, 2'b01, '0);
        tick();
        drive(2'b00, 2'b00, '0);
        check("R6", {60'd0, xb_lock[0]}, 64'd0);

        // R1: reset in the middle of a packet
        drive(2'b10, 2'b00, {2'b10, 32'h0000_0002});
        tick();
        drive(2'b00, 2'b00, '0);
        check("R2", {60'd0, xb_lock[1]}, {60'd0, 4'b0100});
        rst_n = 1'b0;
        tick();
        check_idle("R1");
        rst_n = 1'b1;
        tick();
        check_idle("R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule